// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of an N-bit successive-approximation analog-to-digital converter. A start pulse launches a conversion. The block first raises a one-clock sample/hold strobe for the external track-and-hold. It then runs N bit trials, most significant bit first. In each trial it drives a trial code onto the DAC bus and reads back a one-bit comparator verdict. When the last bit is decided, it raises an end-of-conversion pulse and presents the N-bit code on the result bus.

The comparator, the DAC and the sample-and-hold are outside this block. While a conversion is in flight, further start requests are dropped; they are not remembered.

The result leaves the block as a stream with no back-pressure. The end-of-conversion pulse acts as a one-cycle valid, and there is no ready input. The result bus holds its value until the next end-of-conversion, so a consumer may sample it at any time before then. The start input is a plain control pin.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A start seen high on a clock edge while the block is idle makes the sample/hold strobe high for exactly the next clock cycle. During that cycle the conversion-active signal is low.
- R2: The conversion-active signal is high for exactly N consecutive cycles, starting on the cycle after the sample/hold cycle. In the first of these cycles the DAC code has only its most significant bit set (half scale).
- R3: In the trial for bit b, the DAC code is made of three parts: the bits already decided above b, a 1 at position b, and zeros in every bit below b. Bit b runs from N-1 down to 0.
- R4: A trial bit stays 1 when the comparator input is 1 during its trial cycle (held input at or above the DAC level). It is cleared to 0 when the comparator input is 0.
- R5: The end-of-conversion output is high for exactly one cycle, the cycle right after the last trial. In that same cycle the result bus shows the finished code. The result bus then keeps this value until the next end-of-conversion.
- R6: A start asserted during the sample/hold cycle or during any trial cycle is ignored. It does not change the trial codes or the result, and it does not cause a second sample/hold strobe after the conversion ends.
- R7: During and after reset, the sample/hold strobe, conversion-active, end-of-conversion and result outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| cmp_ge_i | input | 1 | Comparator verdict: 1 when the held input is at or above the DAC level |
| smp_hold_o | output | 1 | Sample/hold strobe, one clock per conversion |
| busy_o | output | 1 | Conversion active, high during the N trial cycles |
| dac_code_o | output | N | Trial code for the external DAC |
| eoc_o | output | 1 | End of conversion; acts as the valid for result_o |
| result_o | output | N | Converted code |

## Verification
The assertions check four things on every cycle:
- the sample/hold strobe lasts a single cycle and is followed by the trial window;
- the first trial code is half scale;
- each trial code has exactly one set bit at or below the bit under trial;
- each decided bit equals the comparator value from its trial, and the result bus changes only together with end-of-conversion.

Other behaviour needs the bench's scenarios. Only they can show that every one of the 256 inputs, fed through an ideal comparator, quantizes to itself. Only they can show the exact length of the active window and that starts during a conversion leave no trace.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
  import sar_seq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output sar_phase_e    phase_o,
  output logic [IW-1:0] idx_o,
  output logic          load_o,
  output logic          step_o,
  output logic          last_o,
  output logic          eoc_o
);
  sar_phase_e    phase_q;
  logic [IW-1:0] idx_q;
  logic          eoc_q;

  assign load_o = (phase_q == PH_IDLE) && start_i;
  assign step_o = (phase_q == PH_TRIAL);
  assign last_o = step_o && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      eoc_q   <= 1'b0;
    end else begin
      eoc_q <= last_o;
      case (phase_q)
        PH_IDLE:   if (start_i) phase_q <= PH_SAMPLE;
        PH_SAMPLE: begin
          phase_q <= PH_TRIAL;
          idx_q   <= IW'(N-1);
        end
        PH_TRIAL: begin
          if (idx_q == '0) phase_q <= PH_IDLE;
          else             idx_q   <= idx_q - 1'b1;
        end
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign eoc_o   = eoc_q;

  // R1: the sample phase lasts one cycle and is always followed by trials
  p_sample_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SAMPLE) |=> (phase_q == PH_TRIAL));

  // R2: trials begin at the most significant bit
  p_first_trial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_TRIAL) |-> (idx_q == IW'(N-1)));

  // R5: end-of-conversion follows the last trial and only that
  p_eoc_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |-> ($past(phase_q) == PH_TRIAL) && (phase_q == PH_IDLE));

  // R6: no sample phase directly after a trial cycle
  p_no_resample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TRIAL) |=> (phase_q != PH_SAMPLE));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [N-1:0]  trial_o,
  output logic [N-1:0]  result_o
);
  logic [N-1:0] trial_q;
  logic [N-1:0] result_q;
  logic [N-1:0] low_mask;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        trial_q[i] <= 1'b0;
      else if (load_i)
        trial_q[i] <= (i == N-1);
      else if (step_i) begin
        if (int'(idx_i) == i)
          trial_q[i] <= cmp_i;
        else if (int'(idx_i) == i+1)
          trial_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      result_q <= '0;
    else if (last_i)
      result_q <= {trial_q[N-1:1], cmp_i};
  end

  always_comb begin
    for (int j = 0; j < N; j++) low_mask[j] = (j <= int'(idx_i));
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;

  // R3: exactly one set bit at or below the bit under trial
  p_trial_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ($countones(trial_q & low_mask) == 1) && trial_q[idx_i]);

  // R4: the decided bit takes the comparator verdict
  p_decision_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (trial_q[$past(idx_i)] == $past(cmp_i)));

  // R5: the result bus moves only with a finishing trial
  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last_i) |-> $stable(result_q));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_ge_i,
  output logic         smp_hold_o,
  output logic         busy_o,
  output logic [N-1:0] dac_code_o,
  output logic         eoc_o,
  output logic [N-1:0] result_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  sar_phase_e    phase;
  logic [IW-1:0] idx;
  logic          load, step, last;

  sar_phase_ctl #(.N(N), .IW(IW)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .phase_o(phase),
    .idx_o  (idx),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .eoc_o  (eoc_o)
  );

  sar_trial_reg #(.N(N), .IW(IW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .step_i  (step),
    .last_i  (last),
    .idx_i   (idx),
    .cmp_i   (cmp_ge_i),
    .trial_o (dac_code_o),
    .result_o(result_o)
  );

  assign smp_hold_o = (phase == PH_SAMPLE);
  assign busy_o     = (phase == PH_TRIAL);

  // R6: a busy cycle is never followed by a sample strobe
  p_busy_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !smp_hold_o);
endmodule

// File: tb/sar_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_seq_ctrl_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp_ge;
  logic         smp_hold, busy, eoc;
  logic [N-1:0] dac_code, result;
  logic [N-1:0] vin_src = '0;
  logic [N-1:0] held = '0;
  int           n_chk = 0;
  int           n_err = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  sar_seq_ctrl #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_ge_i(cmp_ge),
    .smp_hold_o(smp_hold), .busy_o(busy), .dac_code_o(dac_code),
    .eoc_o(eoc), .result_o(result)
  );

  // ideal external track-and-hold and comparator
  always @(posedge clk) if (smp_hold) held <= vin_src;
  assign cmp_ge = (held >= dac_code);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; poke=1 also raises start in the sample cycle and mid-trial
  task automatic run_conv(input int v, input bit poke);
    int exp_dac;
    @(negedge clk);
    vin_src = N'(v);
    start = 1'b1;
    @(negedge clk);
    start = poke;
    chk(smp_hold == 1'b1, "R1 sample strobe", int'(smp_hold), 1);
    chk(busy == 1'b0, "R1 inactive during sample", int'(busy), 0);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      start = poke && (k == 2);
      exp_dac = ((v >> (N-k)) << (N-k)) | (1 << (N-1-k));
      chk(busy == 1'b1, "R2 active window", int'(busy), 1);
      chk(smp_hold == 1'b0, "R6 no strobe in trial", int'(smp_hold), 0);
      chk(int'(dac_code) == exp_dac, "R3 R4 trial code", int'(dac_code), exp_dac);
      chk(eoc == 1'b0, "R5 no early eoc", int'(eoc), 0);
    end
    @(negedge clk);
    start = 1'b0;
    chk(eoc == 1'b1, "R5 eoc pulse", int'(eoc), 1);
    chk(busy == 1'b0, "R2 window length", int'(busy), 0);
    chk(int'(result) == v, "R5 result value", int'(result), v);
    @(negedge clk);
    chk(eoc == 1'b0, "R5 eoc single cycle", int'(eoc), 0);
    chk(smp_hold == 1'b0, "R6 start not queued", int'(smp_hold), 0);
    chk(int'(result) == v, "R5 result hold", int'(result), v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs at zero in reset
    chk(smp_hold == 0 && busy == 0 && eoc == 0, "R7 reset controls",
        int'({smp_hold, busy, eoc}), 0);
    chk(result == '0, "R7 reset result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_hold == 0 && busy == 0 && eoc == 0, "R7 idle after reset",
        int'({smp_hold, busy, eoc}), 0);
    // R1..R5 full sweep of the input range
    for (int v = 0; v < (1 << N); v++) run_conv(v, 1'b0);
    // R6 starts during sample and mid-trial are ignored
    run_conv(8'hA5, 1'b1);
    run_conv(0, 1'b1);
    run_conv((1 << N) - 1, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule